// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is one interrupt file serving a single privilege context. Interrupts reach it as data: a device writes a 32-bit interrupt identity into register offset 0x0 of the file's 4 KB page, and the file marks that identity pending. For each identity the file keeps one pending bit and one enable bit. From these it drives a summary interrupt line and the identity of the best interrupt that is both pending and enabled.

Software reaches the two bit arrays through an indirect port. It places a select address on the port, reads the addressed 32-bit word back combinationally, and can write the word on a clock edge. To take the current top interrupt, the hart pulses a claim strobe. The identity shown on the top-ID output in that cycle is the claimed one, and its pending bit clears at the clock edge.

Top module: `msi_ifile`

## Requirements
- R1: After reset every pending and enable bit is zero, `irq_o` is 0, `top_id_o` is 0, and every implemented select word reads zero.
- R2: A message write at offset 0 with data N, where 1 <= N < NUM_SRC, sets pending bit N at the next clock edge and leaves the other bits unchanged.
- R3: A message write with data 0, with data of NUM_SRC or more (upper bits included), or at any nonzero page offset changes no state.
- R4: Select address 0x80+k reads and writes pending word k, and 0xC0+k reads and writes enable word k, for k < NUM_SRC/32. Bit j of word k belongs to identity 32k+j. A read returns the current state combinationally, and a write (`csr_we_i`) replaces the whole word at the clock edge.
- R5: A select address outside both windows reads as zero, and a write to it changes no state.
- R6: Bit 0 of the pending array and bit 0 of the enable array always read zero. Identity 0 is never an interrupt.
- R7: `top_id_o` is the lowest identity whose pending and enable bits are both set, or 0 when there is none.
- R8: `irq_o` is 1 exactly when `top_id_o` is nonzero. A pending bit whose enable bit is clear does not assert `irq_o`.
- R9: When `claim_i` is high and `top_id_o` is nonzero, the pending bit of that identity clears at the clock edge. A claim while `top_id_o` is 0 changes nothing.
- R10: Updates made in the same cycle are applied in this order: the word write, then the claim clear, then the message set. A message therefore survives a claim or a pending-word write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_wr_i | input | 1 | Message write strobe |
| msg_off_i | input | OFF_W | Byte offset of the write within the page |
| msg_data_i | input | 32 | Written data (interrupt identity) |
| csr_sel_i | input | SEL_W | Indirect select address |
| csr_we_i | input | 1 | Indirect write strobe |
| csr_wdata_i | input | 32 | Indirect write data |
| csr_rdata_o | output | 32 | Indirect read data for the selected word |
| claim_i | input | 1 | Claim strobe for the current top identity |
| top_id_o | output | ID_W | Lowest enabled pending identity, 0 if none |
| irq_o | output | 1 | Any enabled interrupt is pending |

## Verification
The bench covers every identity one at a time and every pair of identities, so an encoder that picks the highest identity, or that loses identities at the word-32 boundary, would show the wrong top value after the first claim. The bench writes identity 0, identities NUM_SRC and 0x8000_0001, and nonzero page offsets. A decoder that truncates the data or ignores the offset would set a stray pending bit. Bit 0 is written with ones, and select addresses just outside both windows are probed, to catch leaking or aliased words. A message in the same cycle as a claim, and a message in the same cycle as a pending-word clear, catch an update order that drops the new message.

// File: rtl/msi_ifile_pkg.sv
package msi_ifile_pkg;

    localparam int WORD_W        = 32;
    localparam int SEL_PEND_BASE = 'h80;
    localparam int SEL_EN_BASE   = 'hC0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_EN   = 2'd2
    } sel_kind_e;

endpackage

// File: rtl/msi_ifile_msgdec.sv
// Turns a page write into a one-hot set vector; invalid writes give zero.
module msi_ifile_msgdec #(
    parameter int NUM_SRC = 64,
    parameter int OFF_W   = 12,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic               wr_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [31:0]        data_i,
    output logic [NUM_SRC-1:0] set_o
);
    logic id_ok;

    always_comb begin
        id_ok = wr_i && (off_i == '0) && (data_i != 32'd0)
                && (data_i < 32'(NUM_SRC));
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_set
        assign set_o[i] = id_ok && (data_i[ID_W-1:0] == ID_W'(i));
    end

endmodule

// File: rtl/msi_ifile_seldec.sv
// Classifies an indirect select address into window kind and word index.
module msi_ifile_seldec
    import msi_ifile_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int SEL_W   = 8,
    localparam int NWORDS = NUM_SRC / WORD_W,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output sel_kind_e        kind_o,
    output logic [IDX_W-1:0] idx_o
);
    int sel_int;

    always_comb begin
        sel_int = int'(sel_i);
        kind_o  = SEL_NONE;
        idx_o   = '0;
        if (sel_int >= SEL_PEND_BASE && sel_int < SEL_PEND_BASE + NWORDS) begin
            kind_o = SEL_PEND;
            idx_o  = IDX_W'(sel_int - SEL_PEND_BASE);
        end else if (sel_int >= SEL_EN_BASE && sel_int < SEL_EN_BASE + NWORDS) begin
            kind_o = SEL_EN;
            idx_o  = IDX_W'(sel_int - SEL_EN_BASE);
        end
    end

endmodule

// File: rtl/msi_ifile_prio.sv
// Fixed priority: lowest nonzero active identity wins.
module msi_ifile_prio #(
    parameter int NUM_SRC = 64,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic [ID_W-1:0]    top_o,
    output logic               any_o
);
    always_comb begin
        top_o = '0;
        for (int i = NUM_SRC - 1; i >= 1; i--) begin
            if (act_i[i]) top_o = ID_W'(i);
        end
        any_o = |act_i[NUM_SRC-1:1];
    end

endmodule

// File: rtl/msi_ifile.sv
module msi_ifile
    import msi_ifile_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int OFF_W   = 12,
    parameter int SEL_W   = 8,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             msg_wr_i,
    input  logic [OFF_W-1:0] msg_off_i,
    input  logic [31:0]      msg_data_i,
    input  logic [SEL_W-1:0] csr_sel_i,
    input  logic             csr_we_i,
    input  logic [31:0]      csr_wdata_i,
    output logic [31:0]      csr_rdata_o,
    input  logic             claim_i,
    output logic [ID_W-1:0]  top_id_o,
    output logic             irq_o
);
    localparam int NWORDS = NUM_SRC / WORD_W;
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] en;
    } ifile_state_t;

    ifile_state_t       st_d, st_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] act_vec;
    sel_kind_e          sel_kind;
    logic [IDX_W-1:0]   sel_idx;

    msi_ifile_msgdec #(.NUM_SRC(NUM_SRC), .OFF_W(OFF_W)) u_msgdec (
        .wr_i   (msg_wr_i),
        .off_i  (msg_off_i),
        .data_i (msg_data_i),
        .set_o  (set_vec)
    );

    msi_ifile_seldec #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_seldec (
        .sel_i  (csr_sel_i),
        .kind_o (sel_kind),
        .idx_o  (sel_idx)
    );

    assign act_vec = st_q.pend & st_q.en;

    msi_ifile_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .act_i (act_vec),
        .top_o (top_id_o),
        .any_o (irq_o)
    );

    // Next state: word write, then claim clear, then message set.
    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NWORDS; k++) begin
            if (csr_we_i && sel_idx == IDX_W'(k)) begin
                if (sel_kind == SEL_PEND) st_d.pend[k*WORD_W +: WORD_W] = csr_wdata_i;
                if (sel_kind == SEL_EN)   st_d.en[k*WORD_W +: WORD_W]   = csr_wdata_i;
            end
        end
        if (claim_i && irq_o) st_d.pend[top_id_o] = 1'b0;
        st_d.pend    = st_d.pend | set_vec;
        st_d.pend[0] = 1'b0;
        st_d.en[0]   = 1'b0;
    end

    always_comb begin
        csr_rdata_o = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if (sel_idx == IDX_W'(k)) begin
                if (sel_kind == SEL_PEND) csr_rdata_o = st_q.pend[k*WORD_W +: WORD_W];
                if (sel_kind == SEL_EN)   csr_rdata_o = st_q.en[k*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // ---------------- assertions ----------------
    logic [NUM_SRC-1:0] chk_claim_vec;
    always_comb begin
        chk_claim_vec = (claim_i && irq_o) ? (NUM_SRC'(1) << top_id_o) : '0;
    end

    // R2
    msg_sets_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_vec != '0) |=> ((st_q.pend & $past(set_vec)) == $past(set_vec)));

    // R3
    bad_offset_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_wr_i && msg_off_i != '0 && !csr_we_i && !claim_i) |=> $stable(st_q.pend));

    // R7
    top_is_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (top_id_o != '0) |-> (st_q.pend[top_id_o] && st_q.en[top_id_o]));

    // R8
    irq_matches_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (top_id_o != '0));

    // R6
    zero_id_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.pend[0] && !st_q.en[0]);

    // R9
    claim_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_i && irq_o && !(csr_we_i && sel_kind == SEL_PEND))
        |=> ((st_q.pend & $past(chk_claim_vec & ~set_vec)) == '0));

endmodule

// File: tb/msi_ifile_tb_top.sv
`timescale 1ns/1ps
module msi_ifile_tb_top;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_wr = 1'b0;
    logic [11:0] msg_off = '0;
    logic [31:0] msg_data = '0;
    logic [7:0]  csr_sel = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        claim = 1'b0;
    logic [5:0]  top_id;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    msi_ifile #(.NUM_SRC(NS), .OFF_W(12), .SEL_W(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .msg_wr_i(msg_wr), .msg_off_i(msg_off), .msg_data_i(msg_data),
        .csr_sel_i(csr_sel), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
        .csr_rdata_o(csr_rdata),
        .claim_i(claim), .top_id_o(top_id), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic msg(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk); msg_wr = 1'b1; msg_off = off; msg_data = d;
        @(negedge clk); msg_wr = 1'b0;
    endtask

    task automatic csr_wr(input logic [7:0] sel, input logic [31:0] d);
        @(negedge clk); csr_sel = sel; csr_we = 1'b1; csr_wdata = d;
        @(negedge clk); csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [7:0] sel, output logic [31:0] v);
        @(negedge clk); csr_sel = sel; #1; v = csr_rdata;
    endtask

    task automatic do_claim();
        @(negedge clk); claim = 1'b1;
        @(negedge clk); claim = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] sel, input logic [31:0] exp, input string req);
        logic [31:0] v;
        csr_rd(sel, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic top_chk(input int exp, input string req);
        #1;
        chk(top_id == 6'(exp), req, 32'(top_id), 32'(exp));
        chk(irq == (exp != 0), "R8", 32'(irq), 32'(exp != 0));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk(irq == 1'b0, "R1", 32'(irq), 0);
        chk(top_id == '0, "R1", 32'(top_id), 0);
        rd_chk(8'h80, 0, "R1"); rd_chk(8'h81, 0, "R1");
        rd_chk(8'hC0, 0, "R1"); rd_chk(8'hC1, 0, "R1");

        // R2 each identity sets exactly its bit; enables off so no irq (R8)
        for (int id = 1; id < NS; id++) begin
            msg(12'h000, 32'(id));
            rd_chk(8'h80, (id < 32) ? (32'd1 << id) : 32'd0, "R2");
            rd_chk(8'h81, (id >= 32) ? (32'd1 << (id - 32)) : 32'd0, "R2");
            chk(irq == 1'b0, "R8", 32'(irq), 0);
            csr_wr(8'h80, 0); csr_wr(8'h81, 0);
        end

        // R3 ignored writes
        msg(12'h000, 32'd0);
        msg(12'h000, 32'd64);
        msg(12'h000, 32'h8000_0001);
        msg(12'h004, 32'd5);
        msg(12'hFFC, 32'd5);
        msg(12'h800, 32'd9);
        rd_chk(8'h80, 0, "R3"); rd_chk(8'h81, 0, "R3");

        // R4 / R6 word access and bit 0
        csr_wr(8'hC0, 32'hFFFF_FFFF);
        rd_chk(8'hC0, 32'hFFFF_FFFE, "R6");
        csr_wr(8'hC1, 32'hFFFF_FFFF);
        rd_chk(8'hC1, 32'hFFFF_FFFF, "R4");
        csr_wr(8'h80, 32'h0000_0001);
        rd_chk(8'h80, 0, "R6");
        csr_wr(8'h81, 32'h1234_5678);
        rd_chk(8'h81, 32'h1234_5678, "R4");
        rd_chk(8'h80, 0, "R4");
        csr_wr(8'h81, 0);

        // R5 unimplemented selects
        csr_wr(8'h82, 32'hFFFF_FFFF);
        csr_wr(8'h7F, 32'hFFFF_FFFF);
        csr_wr(8'hC2, 32'h0);
        csr_wr(8'hBF, 32'hFFFF_FFFF);
        csr_wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h82, 0, "R5"); rd_chk(8'h7F, 0, "R5"); rd_chk(8'hC2, 0, "R5");
        rd_chk(8'h80, 0, "R5"); rd_chk(8'h81, 0, "R5");
        rd_chk(8'hC0, 32'hFFFF_FFFE, "R5"); rd_chk(8'hC1, 32'hFFFF_FFFF, "R5");

        // R7 R9 single identity sweep
        for (int id = 1; id < NS; id++) begin
            msg(12'h000, 32'(id));
            top_chk(id, "R7");
            do_claim();
            top_chk(0, "R9");
        end
        rd_chk(8'h80, 0, "R9"); rd_chk(8'h81, 0, "R9");

        // R7 pair sweep: lower wins, then the other
        for (int a = 1; a < NS; a++) begin
            for (int b = a + 1; b < NS; b++) begin
                msg(12'h000, 32'(b));
                msg(12'h000, 32'(a));
                top_chk(a, "R7");
                do_claim();
                top_chk(b, "R7");
                do_claim();
                top_chk(0, "R9");
            end
        end

        // R7 R8 enable masking: only odd identities in word 0
        csr_wr(8'hC0, 32'hAAAA_AAAA);
        csr_wr(8'hC1, 32'h0);
        for (int id = 1; id < NS; id++) msg(12'h000, 32'(id));
        for (int id = 1; id < 32; id += 2) begin
            top_chk(id, "R7");
            do_claim();
        end
        top_chk(0, "R8");
        rd_chk(8'h80, 32'h5555_5554, "R7");
        rd_chk(8'h81, 32'hFFFF_FFFF, "R7");

        // R9 claim with no top changes nothing
        do_claim();
        rd_chk(8'h80, 32'h5555_5554, "R9");
        rd_chk(8'h81, 32'hFFFF_FFFF, "R9");
        csr_wr(8'hC1, 32'hFFFF_FFFF);
        top_chk(32, "R7");

        // R10 same-cycle ordering
        csr_wr(8'h80, 0); csr_wr(8'h81, 0);
        csr_wr(8'hC0, 32'hFFFF_FFFF);
        msg(12'h000, 32'd5);
        top_chk(5, "R10");
        @(negedge clk); claim = 1'b1; msg_wr = 1'b1; msg_off = '0; msg_data = 32'd5;
        @(negedge clk); claim = 1'b0; msg_wr = 1'b0;
        top_chk(5, "R10");
        @(negedge clk); csr_sel = 8'h80; csr_we = 1'b1; csr_wdata = 32'h0;
        msg_wr = 1'b1; msg_off = '0; msg_data = 32'd7;
        @(negedge clk); csr_we = 1'b0; msg_wr = 1'b0;
        rd_chk(8'h80, 32'h0000_0080, "R10");
        top_chk(7, "R10");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule